// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block drives a single-wire, open-drain serial bus as its master. It accepts one command at a time from a local port. A reset command lowers the line for a long pulse, releases it, and checks whether a slave pulls the line low in answer. A write command sends one byte and a read command gathers one byte. Each byte uses eight fixed-length time slots, least significant bit first.

The line is only ever pulled low through a drive-low enable. To release it, the enable is turned off and an external pull-up raises the line. The level on the line returns through a two-flop synchronizer. All slot and pulse lengths are counted in clock cycles from a clock-frequency parameter. Each length is rounded up so that no interval is shorter than its microsecond figure. The timing is stretched for a 3.3 V bus: a 602 µs reset pulse, a 335 µs window after release, and 70 µs slots.

The controller raises busy while a command runs and pulses done when it ends. The read byte and the presence flag stay on their outputs until the events described below replace them.

Top module: `swire_master`

## Requirements
- R1: A reset command (cmd 2'b00) holds busDriveLow high for 602 µs, then releases the line. Done pulses 335 µs after the release, so busy stays high for 937 µs in total.
- R2: During a reset command the line is sampled 72 µs after release. A high level sets presenceErr to 1 and a low level sets it to 0. The sample reaches the logic through a two-cycle synchronizer, so the level taken is the level the line had exactly 72 µs after release.
- R3: A write command (cmd 2'b01) sends wrData as eight slots, bit 0 first. Each slot is 70 µs long, counted from one rising edge of busDriveLow to the next. A 0 bit drives the line low for 63 µs and a 1 bit drives it low for 7 µs.
- R4: A read command (cmd 2'b10) runs eight slots. Each slot drives the line low for 7 µs and samples the line 9 µs after the slot starts, where low reads as 0. The first slot fills rdData bit 0.
- R5: Busy rises in the cycle after a start is accepted. Busy stays high until the command ends. Done is high for exactly one cycle, with busy low in that cycle. A byte command keeps busy high for 560 µs.
- R6: A start request made while busy is ignored. The running command finishes on its normal schedule, and no further command follows it.
- R7: Command code 2'b11 is not a command. Starting it leaves busy, done and busDriveLow low.
- R8: rdData changes only when a read command completes. presenceErr is cleared when a command is accepted and otherwise changes only at the presence sample of a reset command.
- R9: The line is never driven high. busDriveLow is asserted only while busy is high.
- R10: A synchronous reset returns the controller to idle within one clock. After it, the line is released, busy and done are low, and rdData and presenceErr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Command request, taken only when idle |
| cmd | input | 2 | 00 reset, 01 write byte, 10 read byte, 11 no operation |
| wrData | input | 8 | Byte to send on a write command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| rdData | output | 8 | Last byte received |
| presenceErr | output | 1 | No slave answered the last reset pulse |
| busDriveLow | output | 1 | Pull-down enable for the bus line |
| busLine | input | 1 | Level on the bus line (asynchronous) |

## Verification
The hardest behaviour to reach from the ports is the exact sample instant, because it sits behind the synchronizer delay. For the reads, a slave model holds the line low for a programmable number of cycles after each slot opens. A hold of 9 µs must read as 1 and a hold of 10 µs must read as 0. The presence window gets the same treatment: a slave pulse that ends 71 µs after release must be missed, and one that lasts through 72 µs must be seen. The bench also measures every low pulse and every slot period. From these it rebuilds the written byte, and it injects a start in the middle of a command.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [1:0] {
    CMD_RESET = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_NONE  = 2'b11
  } cmd_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clearFlags;
    logic loadByte;
    logic shiftBit;
    logic useSample;
    logic samplePres;
    logic finishRead;
  } strobe_t;

  // microseconds to clock cycles, rounded up
  function automatic int usToCycles(input longint hz, input int us);
    return int'((hz * longint'(us) + longint'(999_999)) / longint'(1_000_000));
  endfunction

endpackage

// File: rtl/swire_dp.sv
module swire_dp
  import swire_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  strobe_t         strb,
  input  logic [BITS-1:0] wrData,
  input  logic            busLine,
  output logic            curBit,
  output logic [BITS-1:0] rdData,
  output logic            presenceErr
);

  logic [1:0]      syncQ;
  logic            lineS;
  logic [BITS-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= 2'b11;
    else     syncQ <= {syncQ[0], busLine};
  end
  assign lineS = syncQ[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= '0;
    end else if (strb.loadByte) begin
      shiftQ <= wrData;
    end else if (strb.shiftBit) begin
      shiftQ <= {strb.useSample ? lineS : 1'b0, shiftQ[BITS-1:1]};
    end
  end
  assign curBit = shiftQ[0];

  always_ff @(posedge clk) begin
    if (rst)                  rdData <= '0;
    else if (strb.finishRead) rdData <= shiftQ;
  end

  always_ff @(posedge clk) begin
    if (rst)                  presenceErr <= 1'b0;
    else if (strb.clearFlags) presenceErr <= 1'b0;
    else if (strb.samplePres) presenceErr <= lineS;
  end

endmodule

// File: rtl/swire_ctrl.sv
module swire_ctrl
  import swire_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BITS   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] cmd,
  input  logic       curBit,
  output logic       busy,
  output logic       done,
  output logic       driveLow,
  output strobe_t    strb
);

  localparam int RSTL_C   = usToCycles(CLK_HZ, 602);
  localparam int MSP_C    = usToCycles(CLK_HZ, 72);
  localparam int RSTH_C   = usToCycles(CLK_HZ, 68 + 260 + 5 + 2);
  localparam int SLOT_C   = usToCycles(CLK_HZ, 70);
  localparam int W0L_C    = usToCycles(CLK_HZ, 63);
  localparam int W1L_C    = usToCycles(CLK_HZ, 7);
  localparam int RL_C     = usToCycles(CLK_HZ, 7);
  localparam int MSR_C    = usToCycles(CLK_HZ, 9);
  localparam int SYNC_LAT = 2;
  localparam int PRES_PT  = MSP_C + SYNC_LAT;
  localparam int RSMP_PT  = MSR_C + SYNC_LAT;
  localparam int MAX_C    = (RSTL_C > RSTH_C) ? RSTL_C : RSTH_C;
  localparam int CNT_W    = $clog2(MAX_C + 1);
  localparam int IDX_W    = (BITS > 1) ? $clog2(BITS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RLOW, ST_RWAIT, ST_SLOT} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic             isRead;
  logic             accept, lastBit, endRlow, endRwait, endSlot;
  logic [CNT_W-1:0] lowLen;

  assign accept   = (state == ST_IDLE) && start && (cmd_e'(cmd) != CMD_NONE);
  assign lastBit  = (bitIdx == IDX_W'(BITS - 1));
  assign endRlow  = (cnt == CNT_W'(RSTL_C - 1));
  assign endRwait = (cnt == CNT_W'(RSTH_C - 1));
  assign endSlot  = (cnt == CNT_W'(SLOT_C - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    if (isRead)      lowLen = CNT_W'(RL_C);
    else if (curBit) lowLen = CNT_W'(W1L_C);
    else             lowLen = CNT_W'(W0L_C);
  end

  assign driveLow = (state == ST_RLOW) || ((state == ST_SLOT) && (cnt < lowLen));

  always_comb begin
    strb = '0;
    if (accept) begin
      strb.clearFlags = 1'b1;
      strb.loadByte   = (cmd_e'(cmd) == CMD_WRITE);
    end
    if (state == ST_RWAIT && cnt == CNT_W'(PRES_PT)) strb.samplePres = 1'b1;
    if (state == ST_SLOT) begin
      if (isRead && cnt == CNT_W'(RSMP_PT)) begin
        strb.shiftBit  = 1'b1;
        strb.useSample = 1'b1;
      end
      if (!isRead && endSlot) strb.shiftBit = 1'b1;
      if (isRead && endSlot && lastBit) strb.finishRead = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      isRead <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          cnt    <= '0;
          bitIdx <= '0;
          isRead <= (cmd_e'(cmd) == CMD_READ);
          state  <= (cmd_e'(cmd) == CMD_RESET) ? ST_RLOW : ST_SLOT;
        end
        ST_RLOW: begin
          cnt <= endRlow ? '0 : cnt + 1'b1;
          if (endRlow) state <= ST_RWAIT;
        end
        ST_RWAIT: begin
          cnt <= cnt + 1'b1;
          if (endRwait) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        ST_SLOT: begin
          cnt <= cnt + 1'b1;
          if (endSlot) begin
            cnt    <= '0;
            bitIdx <= bitIdx + 1'b1;
            if (lastBit) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/swire_master.sv
module swire_master
  import swire_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BITS   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      cmd,
  input  logic [BITS-1:0] wrData,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] rdData,
  output logic            presenceErr,
  output logic            busDriveLow,
  input  logic            busLine
);

  strobe_t strb;
  logic    curBit;

  swire_ctrl #(.CLK_HZ(CLK_HZ), .BITS(BITS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .curBit(curBit),
    .busy(busy), .done(done), .driveLow(busDriveLow), .strb(strb)
  );

  swire_dp #(.BITS(BITS)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .busLine(busLine),
    .curBit(curBit), .rdData(rdData), .presenceErr(presenceErr)
  );

endmodule

// File: rtl/swire_master_chk.sv
module swire_master_chk #(
  parameter int BITS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            busDriveLow,
  input logic [BITS-1:0] rdData
);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R9
  drive_busy_chk: assert property (@(posedge clk) disable iff (rst) busDriveLow |-> busy);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> !busy);

  // R8
  rddata_hold_chk: assert property (@(posedge clk) disable iff (rst) !$stable(rdData) |-> done);

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start));

endmodule

bind swire_master swire_master_chk #(.BITS(BITS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .busDriveLow(busDriveLow), .rdData(rdData)
);

// File: tb/swire_master_tb.sv
module swire_master_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [7:0] wrData = 8'h00;
  logic       busy, done, presenceErr, busDriveLow, busLine;
  logic [7:0] rdData;
  logic       slavePull = 1'b0;

  assign busLine = !(busDriveLow || slavePull);

  swire_master #(.CLK_HZ(1_000_000), .BITS(8)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .wrData(wrData),
    .busy(busy), .done(done), .rdData(rdData), .presenceErr(presenceErr),
    .busDriveLow(busDriveLow), .busLine(busLine)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;

  // bus monitor and slave model state
  logic prevDrive = 1'b0;
  int lowCnt = 0, nLow = 0, nRise = 0, sinceRise = 0, busyCnt = 0;
  int slotRel = 0, relRel = 0, slotNum = -1;
  int lowLen [0:15];
  int riseGap[0:15];
  bit presMode = 0, readMode = 0, sawBusy = 0, sawDrive = 0;
  int presStart = 20, presLen = 120, holdLen = 20;
  logic [7:0] rdPat = 8'h00;

  always @(negedge clk) begin
    cycles++;
    if (busy) busyCnt++;
    if (busy) sawBusy = 1;
    if (busDriveLow) sawDrive = 1;
    sinceRise++;
    if (busDriveLow) lowCnt++;
    if (busDriveLow && !prevDrive) begin
      if (nRise > 0 && nRise <= 16) riseGap[nRise-1] = sinceRise;
      nRise++;
      sinceRise = 0;
      slotRel = 0;
      slotNum++;
    end else slotRel++;
    if (!busDriveLow && prevDrive) begin
      if (nLow < 16) lowLen[nLow] = lowCnt;
      nLow++;
      lowCnt = 0;
      relRel = 0;
    end else relRel++;
    prevDrive = busDriveLow;
    slavePull = (presMode && relRel >= presStart && relRel < presStart + presLen) ||
                (readMode && slotNum >= 0 && slotNum < 8 && !rdPat[slotNum[2:0]] &&
                 slotRel < holdLen);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // issue one command; injectAt >= 0 pulses a read start that many cycles in
  task automatic runCmd(input logic [1:0] c, input logic [7:0] d, input int injectAt);
    bit got = 0;
    @(negedge clk);
    nLow = 0; nRise = 0; busyCnt = 0; slotNum = -1; lowCnt = 0;
    cmd = c; wrData = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      start = (k == injectAt);
      if (k == injectAt) cmd = 2'b10;
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
    start = 1'b0;
    chk("R5 done seen", int'(got), 1);
  endtask

  localparam logic [9:0] VEC [0:5] = '{
    {2'b01, 8'hA5}, {2'b01, 8'h00}, {2'b01, 8'hFF},
    {2'b10, 8'h3C}, {2'b10, 8'h81}, {2'b00, 8'h01}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 drive", busDriveLow, 0);
    chk("R10 rdData", rdData, 0);
    chk("R10 presErr", presenceErr, 0);

    for (int i = 0; i < 6; i++) begin
      logic [1:0] c;
      logic [7:0] d;
      c = VEC[i][9:8];
      d = VEC[i][7:0];
      if (c == 2'b00) begin
        presMode = d[0]; presStart = 20; presLen = 120;
        runCmd(c, d, -1);
        presMode = 0;
        chk("R2 presErr", presenceErr, int'(!d[0]));
        chk("R1 low len", lowLen[0], 602);
        chk("R1 busy len", busyCnt, 937);
      end else if (c == 2'b01) begin
        logic [7:0] got;
        runCmd(c, d, -1);
        got = '0;
        chk("R3 slots", nLow, 8);
        for (int b = 0; b < 8; b++) begin
          got[b] = (lowLen[b] < 30);
          chk("R3 low len", lowLen[b], d[b] ? 7 : 63);
        end
        for (int b = 0; b < 7; b++) chk("R3 slot period", riseGap[b], 70);
        chk("R3 byte lsb first", got, d);
        chk("R5 byte busy", busyCnt, 560);
      end else begin
        readMode = 1; rdPat = d; holdLen = 20;
        runCmd(c, d, -1);
        readMode = 0;
        chk("R4 rdData", rdData, d);
        for (int b = 0; b < 8; b++) chk("R4 low len", lowLen[b], 7);
        chk("R5 byte busy", busyCnt, 560);
      end
    end

    // R6 start during reset ignored; no slave -> error
    presMode = 0;
    runCmd(2'b00, 8'h00, 100);
    chk("R6 busy len", busyCnt, 937);
    chk("R2 no slave", presenceErr, 1);
    sawBusy = 0;
    repeat (20) @(negedge clk);
    chk("R6 no follow-on", sawBusy, 0);
    chk("R8 rdData kept over reset", rdData, 8'h81);

    // R8 accepted write clears presence error, keeps rdData
    runCmd(2'b01, 8'h5A, -1);
    chk("R8 presErr cleared", presenceErr, 0);
    chk("R8 rdData kept over write", rdData, 8'h81);

    // R2 presence sample point boundary
    presMode = 1; presStart = 20; presLen = 52;
    runCmd(2'b00, 8'h00, -1);
    chk("R2 pulse ends at 71", presenceErr, 1);
    presLen = 53;
    runCmd(2'b00, 8'h00, -1);
    chk("R2 pulse through 72", presenceErr, 0);
    presMode = 0;

    // R4 read sample point boundary
    readMode = 1; rdPat = 8'h00; holdLen = 9;
    runCmd(2'b10, 8'h00, -1);
    chk("R4 hold 9 reads one", rdData, 8'hFF);
    holdLen = 10;
    runCmd(2'b10, 8'h00, -1);
    chk("R4 hold 10 reads zero", rdData, 8'h00);
    readMode = 0;

    // R7 no-operation code
    @(negedge clk);
    sawBusy = 0; sawDrive = 0;
    cmd = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 no busy", sawBusy, 0);
    chk("R7 no drive", sawDrive, 0);
    chk("R9 idle line released", busDriveLow, 0);

    // R10 synchronous reset during a slot
    @(negedge clk);
    cmd = 2'b01; wrData = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R9 driving in slot", busDriveLow, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 drive after rst", busDriveLow, 0);
    chk("R10 busy after rst", busy, 0);
    chk("R10 rdData after rst", rdData, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 stays idle", busy, 0);

    finishRun();
  end

endmodule